// File: doc/BRIEF.md
# Sector-Tagged Test Pattern Generator and Checker

This block drives a storage data path at full rate during throughput tests. In a write run it creates a stream of 32-bit words and pushes them into a write FIFO. In a read run it empties a read FIFO and compares every word with the same stream, generated a second time. The stream is split into sectors of `SECT_DW` words. The first two words of each sector carry a 64-bit tag that holds the sector's address. Every sector's data is therefore distinct, and a word that arrives in the wrong place is detected after readback.

A run starts with a one-cycle strobe. The block samples four values in that cycle: a file index, a file count, a 3-bit size code and a 3-bit pattern select. It then moves words whenever the FIFO allows, with no bubble. It keeps a byte progress count. When the last word moves, the run ends by itself. In a read run, the first mismatching word is kept for later inspection: the expected value, the received value and the byte offset.

Top module: `sector_pattern_engine`

## Requirements
- R1: While reset is held, and after it is released, `runActive`, `wffWrEn`, `rffRdEn`, `byteCount` and `patFail` are all 0.
- R2: `wffWrEn` is high in exactly those cycles in which a write run is active and `wffAlmostFull` is low. Each such cycle transfers the word on `wffWrData`.
- R3: A run moves `fileCnt << (sizeCode + BASE_SECT_LOG)` sectors of `SECT_DW` words each. `runActive` clears in the cycle after the last transfer. `byteCount` starts at 0 when the run begins and adds 4 for each word. A file count of 0 starts no run.
- R4: `rffRdEn` equals "read run active AND NOT `rffEmpty`". The word on `rffRdData` is consumed in every cycle in which `rffRdEn` is high.
- R5: Word 0 of each sector is bits 31:0 of its sector address and word 1 is bits 63:32. The first sector address is `fileIdx << (sizeCode + BASE_SECT_LOG)`, and each following sector adds one.
- R6: Pattern code 000 (increment) makes word d (d ≥ 2) equal to the low 32 bits of the sector address plus d, modulo 2^32.
- R7: Pattern code 001 (decrement) makes every data word the bitwise inverse of the word that code 000 would give.
- R8: Code 010 gives all-zero data words, code 011 gives all-one data words, and codes 101, 110 and 111 give all-zero data words.
- R9: Code 100 (LFSR) makes word d (d ≥ 2) equal to L applied d times to the low 32 bits of the sector address, where L(s) = {s[30:0], s[31]^s[21]^s[1]}.
- R10: A read word that differs from the expected word sets `patFail` one cycle after its transfer. The first such word loads `failExpected`, `failReceived` and `failOffset` (word number × 4). Later mismatches do not change these registers. All of them hold until the next accepted start, which clears them.
- R11: A start strobe that arrives while a run is active is ignored. If both strobes arrive together while idle, a write run starts.
- R12: The file index, file count, size code and pattern select are sampled only in the cycle a run is accepted. Changing them during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startWr | input | 1 | Start a write run |
| startRd | input | 1 | Start a read run |
| fileIdx | input | FIDX_W | First file number of the run |
| fileCnt | input | FCNT_W | Number of files in the run |
| sizeCode | input | 3 | Per-file size code |
| patSel | input | 3 | Pattern select |
| wffAlmostFull | input | 1 | Write FIFO almost full |
| wffWrEn | output | 1 | Write FIFO push |
| wffWrData | output | 32 | Generated word |
| rffEmpty | input | 1 | Read FIFO empty |
| rffRdEn | output | 1 | Read FIFO pop |
| rffRdData | input | 32 | Word from read FIFO |
| runActive | output | 1 | A run is in progress |
| byteCount | output | BYTE_W | Bytes moved in this run |
| patFail | output | 1 | Sticky mismatch flag |
| failExpected | output | 32 | Expected word at the first mismatch |
| failReceived | output | 32 | Received word at the first mismatch |
| failOffset | output | BYTE_W | Byte offset of the first mismatch |

## Verification
Two events can fall in the same cycle: the transfer that ends the run and the first mismatch that must be captured. The bench corrupts the final word of a read run and then checks three things. `runActive` has cleared, `patFail` is set, and the capture registers hold that word's offset and values. A second pair is a start strobe that arrives during the data stream. The bench pulses a read start in the middle of a write run and also changes the pattern select at that time. It then checks, word by word, that the write stream continues with its original pattern and that no read enable appears.

// File: rtl/spg_pkg.sv
package spg_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;   // run accepted: sample run parameters, clear capture
    logic adv;    // one word moved this cycle
    logic chk;    // the moved word is a read word to compare
  } spg_strobe_t;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_READ  = 2'd2
  } spg_mode_t;

  localparam logic [2:0] PAT_INC  = 3'd0;
  localparam logic [2:0] PAT_DEC  = 3'd1;
  localparam logic [2:0] PAT_ZERO = 3'd2;
  localparam logic [2:0] PAT_ONE  = 3'd3;
  localparam logic [2:0] PAT_LFSR = 3'd4;

  // Shift-left step; feedback taps come from the x^31, x^21 and x terms.
  function automatic logic [31:0] lfsrNext(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1]};
  endfunction

endpackage

// File: rtl/spg_ctrl.sv
module spg_ctrl
  import spg_pkg::*;
#(
  parameter int SECT_LOG      = 7,
  parameter int BASE_SECT_LOG = 16,
  parameter int FCNT_W        = 16,
  parameter int CNT_W         = 46
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWr,
  input  logic              startRd,
  input  logic [FCNT_W-1:0] fileCnt,
  input  logic [2:0]        sizeCode,
  input  logic              wffAlmostFull,
  input  logic              rffEmpty,
  output logic              wffWrEn,
  output logic              rffRdEn,
  output logic              runActive,
  output spg_strobe_t       strobe,
  output logic [CNT_W-1:0]  wordCount
);

  localparam int FIXED_SHIFT = BASE_SECT_LOG + SECT_LOG;

  spg_mode_t        mode;
  logic [CNT_W-1:0] endWords;
  logic [CNT_W-1:0] reqWords;
  logic [7:0]       shAmt;
  logic             accept;
  logic             xfer;
  logic             lastXfer;

  always_comb begin
    shAmt    = 8'(sizeCode) + 8'(FIXED_SHIFT);
    reqWords = CNT_W'(fileCnt) << shAmt;
    accept   = (mode == MODE_IDLE) && (startWr || startRd);
    wffWrEn  = (mode == MODE_WRITE) && !wffAlmostFull;
    rffRdEn  = (mode == MODE_READ) && !rffEmpty;
    xfer     = wffWrEn || rffRdEn;
    lastXfer = xfer && ((wordCount + CNT_W'(1)) == endWords);
    runActive = (mode != MODE_IDLE);
    strobe.load = accept;
    strobe.adv  = xfer;
    strobe.chk  = rffRdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MODE_IDLE;
      wordCount <= '0;
      endWords  <= '0;
    end else if (accept) begin
      wordCount <= '0;
      endWords  <= reqWords;
      if (reqWords == '0)
        mode <= MODE_IDLE;
      else if (startWr)
        mode <= MODE_WRITE;
      else
        mode <= MODE_READ;
    end else if (xfer) begin
      wordCount <= wordCount + CNT_W'(1);
      if (lastXfer)
        mode <= MODE_IDLE;
    end
  end

endmodule

// File: rtl/spg_datapath.sv
module spg_datapath
  import spg_pkg::*;
#(
  parameter int SECT_LOG      = 7,
  parameter int BASE_SECT_LOG = 16,
  parameter int FIDX_W        = 16,
  parameter int SEC_W         = 39,
  parameter int CNT_W         = 46,
  parameter int BYTE_W        = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  spg_strobe_t       strobe,
  input  logic [FIDX_W-1:0] fileIdx,
  input  logic [2:0]        sizeCode,
  input  logic [2:0]        patSel,
  input  logic [31:0]       rffRdData,
  input  logic [CNT_W-1:0]  wordCount,
  output logic [31:0]       expWord,
  output logic              patFail,
  output logic [31:0]       failExpected,
  output logic [31:0]       failReceived,
  output logic [BYTE_W-1:0] failOffset
);

  logic [SECT_LOG-1:0] wordIdx;
  logic [SEC_W-1:0]    secAddr;
  logic [31:0]         lfsr;
  logic [2:0]          patR;
  logic [63:0]         hdr;
  logic [31:0]         incWord;
  logic [7:0]          shAmt;
  logic                sectLast;
  logic                mismatch;

  always_comb begin
    shAmt    = 8'(sizeCode) + 8'(BASE_SECT_LOG);
    hdr      = 64'(secAddr);
    incWord  = hdr[31:0] + 32'(wordIdx);
    sectLast = &wordIdx;
    if (wordIdx == SECT_LOG'(0))
      expWord = hdr[31:0];
    else if (wordIdx == SECT_LOG'(1))
      expWord = hdr[63:32];
    else begin
      case (patR)
        PAT_INC:  expWord = incWord;
        PAT_DEC:  expWord = ~incWord;
        PAT_ONE:  expWord = '1;
        PAT_LFSR: expWord = lfsr;
        default:  expWord = '0;
      endcase
    end
    mismatch = strobe.chk && (rffRdData != expWord);
  end

  // Position within the sector and sector tag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx <= '0;
      secAddr <= '0;
      patR    <= PAT_INC;
    end else if (strobe.load) begin
      wordIdx <= '0;
      secAddr <= SEC_W'(fileIdx) << shAmt;
      patR    <= patSel;
    end else if (strobe.adv) begin
      wordIdx <= wordIdx + SECT_LOG'(1);
      if (sectLast)
        secAddr <= secAddr + SEC_W'(1);
    end
  end

  // LFSR restarts from the tag in word 0 and steps once per word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      lfsr <= '0;
    else if (strobe.adv)
      lfsr <= (wordIdx == SECT_LOG'(0)) ? lfsrNext(hdr[31:0]) : lfsrNext(lfsr);
  end

  // First-mismatch capture.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patFail      <= 1'b0;
      failExpected <= '0;
      failReceived <= '0;
      failOffset   <= '0;
    end else if (strobe.load) begin
      patFail      <= 1'b0;
      failExpected <= '0;
      failReceived <= '0;
      failOffset   <= '0;
    end else if (mismatch && !patFail) begin
      patFail      <= 1'b1;
      failExpected <= expWord;
      failReceived <= rffRdData;
      failOffset   <= {wordCount, 2'b00};
    end
  end

endmodule

// File: rtl/sector_pattern_engine.sv
module sector_pattern_engine
  import spg_pkg::*;
#(
  parameter int SECT_DW       = 128,
  parameter int BASE_SECT_LOG = 16,
  parameter int FIDX_W        = 16,
  parameter int FCNT_W        = 16,
  localparam int SECT_LOG     = $clog2(SECT_DW),
  localparam int SEC_W        = FIDX_W + BASE_SECT_LOG + 7,
  localparam int CNT_W        = FCNT_W + BASE_SECT_LOG + 7 + SECT_LOG,
  localparam int BYTE_W       = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWr,
  input  logic              startRd,
  input  logic [FIDX_W-1:0] fileIdx,
  input  logic [FCNT_W-1:0] fileCnt,
  input  logic [2:0]        sizeCode,
  input  logic [2:0]        patSel,
  input  logic              wffAlmostFull,
  output logic              wffWrEn,
  output logic [31:0]       wffWrData,
  input  logic              rffEmpty,
  output logic              rffRdEn,
  input  logic [31:0]       rffRdData,
  output logic              runActive,
  output logic [BYTE_W-1:0] byteCount,
  output logic              patFail,
  output logic [31:0]       failExpected,
  output logic [31:0]       failReceived,
  output logic [BYTE_W-1:0] failOffset
);

  spg_strobe_t      strobe;
  logic [CNT_W-1:0] wordCount;

  spg_ctrl #(
    .SECT_LOG(SECT_LOG), .BASE_SECT_LOG(BASE_SECT_LOG),
    .FCNT_W(FCNT_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startRd(startRd),
    .fileCnt(fileCnt), .sizeCode(sizeCode),
    .wffAlmostFull(wffAlmostFull), .rffEmpty(rffEmpty),
    .wffWrEn(wffWrEn), .rffRdEn(rffRdEn), .runActive(runActive),
    .strobe(strobe), .wordCount(wordCount)
  );

  spg_datapath #(
    .SECT_LOG(SECT_LOG), .BASE_SECT_LOG(BASE_SECT_LOG), .FIDX_W(FIDX_W),
    .SEC_W(SEC_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fileIdx(fileIdx),
    .sizeCode(sizeCode), .patSel(patSel), .rffRdData(rffRdData),
    .wordCount(wordCount), .expWord(wffWrData), .patFail(patFail),
    .failExpected(failExpected), .failReceived(failReceived),
    .failOffset(failOffset)
  );

  assign byteCount = {wordCount, 2'b00};

endmodule

// File: rtl/spg_checker.sv
module spg_checker #(
  parameter int BYTE_W = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic              startWr,
  input logic              startRd,
  input logic              wffAlmostFull,
  input logic              wffWrEn,
  input logic              rffEmpty,
  input logic              rffRdEn,
  input logic              runActive,
  input logic [BYTE_W-1:0] byteCount,
  input logic              patFail,
  input logic [BYTE_W-1:0] failOffset
);

  // R2
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    wffWrEn |-> (!wffAlmostFull && runActive));

  // R4
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    rffRdEn |-> (!rffEmpty && runActive));

  // R11
  one_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wffWrEn && rffRdEn));

  // R3
  progress_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wffWrEn || rffRdEn) |=> (byteCount == $past(byteCount) + BYTE_W'(4)));

  // R3
  progress_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wffWrEn && !rffRdEn && !startWr && !startRd) |=> $stable(byteCount));

  // R10
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (patFail && !startWr && !startRd) |=> (patFail && $stable(failOffset)));

endmodule

bind sector_pattern_engine spg_checker #(.BYTE_W(BYTE_W)) u_spg_chk (
  .clk(clk), .rstN(rstN), .startWr(startWr), .startRd(startRd),
  .wffAlmostFull(wffAlmostFull), .wffWrEn(wffWrEn), .rffEmpty(rffEmpty),
  .rffRdEn(rffRdEn), .runActive(runActive), .byteCount(byteCount),
  .patFail(patFail), .failOffset(failOffset)
);

// File: tb/sim_sector_pattern_engine.sv
module sim_sector_pattern_engine;

  localparam int SECT_DW = 128;
  localparam int BASE    = 0;
  localparam int FIDX_W  = 8;
  localparam int FCNT_W  = 4;
  localparam int BYTE_W  = FCNT_W + BASE + 7 + 7 + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startWr = 1'b0, startRd = 1'b0;
  logic [FIDX_W-1:0] fileIdx = '0;
  logic [FCNT_W-1:0] fileCnt = '0;
  logic [2:0] sizeCode = '0, patSel = '0;
  logic wffAlmostFull = 1'b0, rffEmpty = 1'b1;
  logic wffWrEn, rffRdEn, runActive, patFail;
  logic [31:0] wffWrData, failExpected, failReceived;
  logic [31:0] rffRdData = '0;
  logic [BYTE_W-1:0] byteCount, failOffset;

  int nVec = 0, nMis = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sector_pattern_engine #(
    .SECT_DW(SECT_DW), .BASE_SECT_LOG(BASE), .FIDX_W(FIDX_W), .FCNT_W(FCNT_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startRd(startRd),
    .fileIdx(fileIdx), .fileCnt(fileCnt), .sizeCode(sizeCode), .patSel(patSel),
    .wffAlmostFull(wffAlmostFull), .wffWrEn(wffWrEn), .wffWrData(wffWrData),
    .rffEmpty(rffEmpty), .rffRdEn(rffRdEn), .rffRdData(rffRdData),
    .runActive(runActive), .byteCount(byteCount), .patFail(patFail),
    .failExpected(failExpected), .failReceived(failReceived),
    .failOffset(failOffset)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nVec++;
    if (!ok) begin
      nMis++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lstep(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1]};
  endfunction

  // Expected word k of a run, from the requirements.
  function automatic logic [31:0] model(input int fidx, input int code,
                                        input int pat, input int k);
    int unsigned a;
    int d;
    logic [31:0] s;
    a = (fidx << (code + BASE)) + (k / SECT_DW);
    d = k % SECT_DW;
    if (d == 0) return a;
    if (d == 1) return 32'h0;
    case (pat)
      0: return a + d;
      1: return ~(a + d);
      3: return 32'hFFFF_FFFF;
      4: begin
        s = a;
        for (int i = 0; i < d; i++) s = lstep(s);
        return s;
      end
      default: return 32'h0;
    endcase
  endfunction

  task automatic runWrite(input int fidx, input int cnt, input int code,
                          input int pat, input bit disturb, input bit both);
    int total, k, cyc;
    total = (cnt << (code + BASE)) * SECT_DW;
    k = 0; cyc = 0;
    @(negedge clk);
    fileIdx = FIDX_W'(fidx); fileCnt = FCNT_W'(cnt);
    sizeCode = 3'(code); patSel = 3'(pat);
    rffEmpty = 1'b0; wffAlmostFull = 1'b0;
    startWr = 1'b1; startRd = both;
    forever begin
      @(negedge clk);
      startWr = 1'b0; startRd = 1'b0;
      wffAlmostFull = ($urandom % 4) == 0;
      if (disturb && cyc == 10) begin
        startRd = 1'b1; patSel = ~patSel; fileIdx = ~fileIdx;
        fileCnt = '1;
      end
      cyc++;
      #1;
      if (!runActive) break;
      check(rffRdEn == 1'b0, "R11 no read during write", rffRdEn, 0);
      check(wffWrEn == !wffAlmostFull, "R2 write gating", wffWrEn, !wffAlmostFull);
      if (wffWrEn) begin
        check(wffWrData == model(fidx, code, pat, k), "R5-R9 write word (R12)",
              wffWrData, model(fidx, code, pat, k));
        k++;
      end
    end
    check(k == total, "R3 word total", k, total);
    check(byteCount == BYTE_W'(total * 4), "R3 byte count", byteCount, total * 4);
    check(wffWrEn == 1'b0, "R2 idle after run", wffWrEn, 0);
  endtask

  task automatic runRead(input int fidx, input int cnt, input int code,
                         input int pat, input int err1, input int err2);
    int total, k;
    total = (cnt << (code + BASE)) * SECT_DW;
    k = 0;
    @(negedge clk);
    fileIdx = FIDX_W'(fidx); fileCnt = FCNT_W'(cnt);
    sizeCode = 3'(code); patSel = 3'(pat);
    wffAlmostFull = 1'b0; rffEmpty = 1'b1;
    startRd = 1'b1;
    forever begin
      @(negedge clk);
      startRd = 1'b0;
      rffEmpty = ($urandom % 3) == 0;
      rffRdData = model(fidx, code, pat, k) ^ ((k == err1 || k == err2) ? 32'h10 : 32'h0);
      #1;
      if (!runActive) break;
      check(rffRdEn == !rffEmpty, "R4 read gating", rffRdEn, !rffEmpty);
      check(wffWrEn == 1'b0, "R4 no write during read", wffWrEn, 0);
      if (rffRdEn) k++;
    end
    check(k == total, "R3 read total", k, total);
    check(byteCount == BYTE_W'(total * 4), "R3 read byte count", byteCount, total * 4);
    if (err1 < 0) begin
      check(patFail == 1'b0, "R10 clean read", patFail, 0);
    end else begin
      check(patFail == 1'b1, "R10 fail flag", patFail, 1);
      check(failOffset == BYTE_W'(err1 * 4), "R10 fail offset", failOffset, err1 * 4);
      check(failExpected == model(fidx, code, pat, err1), "R10 fail expected",
            failExpected, model(fidx, code, pat, err1));
      check(failReceived == (model(fidx, code, pat, err1) ^ 32'h10), "R10 fail received",
            failReceived, model(fidx, code, pat, err1) ^ 32'h10);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nVec++; nMis++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
      $finish;
    end
  end

  initial begin : main
    int seedDummy;
    seedDummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!runActive && !wffWrEn && !rffRdEn && byteCount == '0 && !patFail,
          "R1 in reset", {runActive, wffWrEn, rffRdEn, patFail}, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(!runActive && !wffWrEn && !rffRdEn && byteCount == '0 && !patFail,
          "R1 after reset", {runActive, wffWrEn, rffRdEn, patFail}, 0);

    // directed write runs, one per pattern code (R6 R7 R8 R9)
    runWrite(3, 2, 1, 0, 1'b1, 1'b0);
    runWrite(5, 1, 0, 1, 1'b0, 1'b0);
    runWrite(7, 1, 1, 2, 1'b0, 1'b0);
    runWrite(9, 1, 0, 3, 1'b0, 1'b0);
    runWrite(11, 2, 0, 4, 1'b0, 1'b0);
    runWrite(13, 1, 0, 6, 1'b0, 1'b0);
    // R11 simultaneous starts: write wins
    runWrite(2, 1, 0, 0, 1'b0, 1'b1);

    // R3 file count zero starts nothing and clears progress
    @(negedge clk);
    fileCnt = '0; startWr = 1'b1;
    @(negedge clk);
    startWr = 1'b0; #1;
    check(runActive == 1'b0, "R3 zero count no run", runActive, 0);
    check(byteCount == '0, "R3 zero count progress", byteCount, 0);

    // read runs
    runRead(4, 1, 1, 0, -1, -1);
    runRead(6, 2, 0, 4, 5, 20);
    runRead(8, 1, 0, 1, 127, -1);          // mismatch on final word
    runRead(1, 1, 0, 3, -1, -1);           // R10 new start clears fail

    // constrained random
    for (int r = 0; r < 6; r++) begin
      int f, c, z, p, e;
      f = 1 + ($urandom % 200);
      c = 1 + ($urandom % 3);
      z = $urandom % 3;
      p = $urandom % 8;
      runWrite(f, c, z, p, 1'b0, 1'b0);
      e = (r % 2 == 0) ? -1 : int'($urandom % ((c << z) * SECT_DW));
      runRead(f, c, z, p, e, -1);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
    $finish;
  end

endmodule